// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block issues the multi-cycle command sequences that a parallel NOR flash expects on its byte-wide write/read port. A single start pulse, together with an operation code, begins one of five operations: identification probe, sector erase, block erase, whole-device erase, or the program-setup prefix that precedes a data byte. Every sequence opens with the two-cycle unlock pair. The unlock addresses are folded through a mask chosen per device, so that parts with narrower address decoding can be used as well.

The sequencer waits a minimum number of idle clocks between bus cycles. The wait is derived from a clock-frequency parameter and from microsecond parameters. For a probe it enters identification mode and reads the maker and device bytes. Each byte that holds the continuation code is extended with a second read. It then leaves identification mode with either a short or a long exit sequence and reports whether both identities match the expected values. After an erase command the block does not poll the device itself: it raises a request to an external ready poller and waits for the poller's acknowledge.

Top module: `flash_cmd_seq`

## Requirements
- R1: Each sequence starts with 0xAA written to (0x5555 AND mask) and then 0x55 written to (0x2AAA AND mask). Every erase repeats this unlock pair after its 0x80 cycle, and a long exit also repeats it.
- R2: `mask_sel` 0 selects mask 0xFFFF, 1 selects 0x07FF and 2 selects 0x0FFF. Value 3, or an `op` code above 4, makes the block pulse `done` together with `err` on the clock after `start`. In that case it issues no bus cycle and `busy` stays low.
- R3: Program setup (`op`=4) is the unlock pair followed by 0xA0 written to the masked 0x5555.
- R4: An erase is the unlock pair, 0x80 to the masked 0x5555 and a second unlock pair. The last cycle is 0x30 to `target_addr` for a sector erase (`op`=1), 0x50 to `target_addr` for a block erase (`op`=2), or 0x10 to the masked 0x5555 for a device erase (`op`=3). `target_addr` is never masked.
- R5: A probe (`op`=0) is the unlock pair, then 0x90 to the masked 0x5555, then a read at address 0 (maker) and a read at address 1 (device).
- R6: When the maker byte reads 0x7F, one extra read follows at 0x100, and `mfr_id` becomes {0x7F, that byte}. The device byte behaves the same way with its extra read at 0x101. Otherwise the ID is the byte zero-extended to 16 bits. The maker extension read comes before the device extension read.
- R7: A probe ends with 0xF0 written to the masked 0x5555. When `long_exit` is 1, the unlock pair is written before it.
- R8: Idle clocks between bus cycles are at least CLK_MHZ*CMD_GAP_US for erase and program-setup cycles. After the 0x90 write they are at least CLK_MHZ*PROBE_ENTRY_US. After the 0xF0 write, at least CLK_MHZ*PROBE_EXIT_US idle clocks pass before `done`. The probe's unlock cycles use the command gap, or no gap when the matching probe delay is zero. Every strobe lasts one clock.
- R9: After a probe, `id_match` is 1 only if `mfr_id` equals `exp_mfr` and `dev_id` equals `exp_dev`.
- R10: After a probe, `parity_warn` is 1 when the low byte of `mfr_id` has even parity (an even count of ones).
- R11: After the last erase cycle and its gap, `poll_req` stays high with no bus cycles until `poll_done` is sampled high. It falls on the following clock, and `done` follows after that.
- R12: `busy` is high from the clock after an accepted `start` until the clock on which `done` pulses. A `start` that arrives while `busy` is high is ignored, and each operation gives exactly one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts an operation while idle |
| op | input | 3 | 0 probe, 1 sector erase, 2 block erase, 3 device erase, 4 program setup |
| mask_sel | input | 2 | Unlock address mask select |
| long_exit | input | 1 | Selects the long exit sequence for a probe |
| target_addr | input | ADDR_W | Sector or block address for an erase |
| exp_mfr | input | 16 | Expected maker ID |
| exp_dev | input | 16 | Expected device ID |
| bus_wr | output | 1 | One-clock write strobe |
| bus_rd | output | 1 | One-clock read strobe |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid during the read strobe |
| poll_req | output | 1 | Asks the external poller to wait for erase completion |
| poll_done | input | 1 | Poller acknowledge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Pulses with `done` when the operation was rejected |
| mfr_id | output | 16 | Extended maker ID from the last probe |
| dev_id | output | 16 | Extended device ID from the last probe |
| id_match | output | 1 | Both IDs matched the expected values |
| parity_warn | output | 1 | Maker byte failed the odd-parity check |

## Verification
The bench targets the narrow masks, where a design that applied the mask to `target_addr` or skipped masking the unlock addresses would put the wrong address on the bus. It runs probes with and without continuation codes and in both exit modes. A design that ignored the continuation code would return 8-bit IDs and leave out the 0x100/0x101 reads. One that got the exit mode backwards would add or drop the unlock pair before 0xF0. Each gap is measured against its own minimum, so a design that reused the short command gap after the 0x90 write would be caught. A second `start` is injected during the erase poll wait; a design that accepted it would produce extra strobes or an extra `done`.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [2:0] OP_PROBE = 3'd0;
  localparam logic [2:0] OP_SECT  = 3'd1;
  localparam logic [2:0] OP_BLK   = 3'd2;
  localparam logic [2:0] OP_CHIP  = 3'd3;
  localparam logic [2:0] OP_PSET  = 3'd4;

  localparam logic [7:0]  CONT_CODE = 8'h7F;
  localparam logic [15:0] UNLK_A1   = 16'h5555;
  localparam logic [15:0] UNLK_A2   = 16'h2AAA;

  typedef enum logic [1:0] {K_WR, K_RD, K_POLL, K_END} step_kind_e;
  typedef enum logic [2:0] {A_UNLK1, A_UNLK2, A_TGT, A_ID_M0, A_ID_D0, A_ID_M1, A_ID_D1} addr_src_e;
  typedef enum logic [2:0] {G_NONE, G_CMD, G_PUNLK, G_ENTRY, G_XUNLK, G_EXIT} gap_src_e;
  typedef enum logic [1:0] {C_ALW, C_MCONT, C_DCONT, C_LONG} cond_e;

  typedef struct packed {
    step_kind_e kind;
    addr_src_e  asrc;
    logic [7:0] data;
    gap_src_e   gsrc;
    cond_e      cond;
  } step_t;

  function automatic step_t mk(step_kind_e k, addr_src_e a, logic [7:0] d, gap_src_e g, cond_e c);
    step_t s;
    s.kind = k;
    s.asrc = a;
    s.data = d;
    s.gsrc = g;
    s.cond = c;
    return s;
  endfunction

  // Micro-program: one step per program counter value
  function automatic step_t step_of(logic [2:0] op, logic [3:0] pc);
    step_t s;
    s = mk(K_END, A_UNLK1, 8'h00, G_NONE, C_ALW);
    if (op == OP_PROBE) begin
      case (pc)
        4'd0: s = mk(K_WR, A_UNLK1, 8'hAA, G_PUNLK, C_ALW);
        4'd1: s = mk(K_WR, A_UNLK2, 8'h55, G_PUNLK, C_ALW);
        4'd2: s = mk(K_WR, A_UNLK1, 8'h90, G_ENTRY, C_ALW);
        4'd3: s = mk(K_RD, A_ID_M0, 8'h00, G_NONE, C_ALW);
        4'd4: s = mk(K_RD, A_ID_D0, 8'h00, G_NONE, C_ALW);
        4'd5: s = mk(K_RD, A_ID_M1, 8'h00, G_NONE, C_MCONT);
        4'd6: s = mk(K_RD, A_ID_D1, 8'h00, G_NONE, C_DCONT);
        4'd7: s = mk(K_WR, A_UNLK1, 8'hAA, G_XUNLK, C_LONG);
        4'd8: s = mk(K_WR, A_UNLK2, 8'h55, G_XUNLK, C_LONG);
        4'd9: s = mk(K_WR, A_UNLK1, 8'hF0, G_EXIT, C_ALW);
        default: s = mk(K_END, A_UNLK1, 8'h00, G_NONE, C_ALW);
      endcase
    end else if (op == OP_PSET) begin
      case (pc)
        4'd0: s = mk(K_WR, A_UNLK1, 8'hAA, G_CMD, C_ALW);
        4'd1: s = mk(K_WR, A_UNLK2, 8'h55, G_CMD, C_ALW);
        4'd2: s = mk(K_WR, A_UNLK1, 8'hA0, G_CMD, C_ALW);
        default: s = mk(K_END, A_UNLK1, 8'h00, G_NONE, C_ALW);
      endcase
    end else begin
      case (pc)
        4'd0: s = mk(K_WR, A_UNLK1, 8'hAA, G_CMD, C_ALW);
        4'd1: s = mk(K_WR, A_UNLK2, 8'h55, G_CMD, C_ALW);
        4'd2: s = mk(K_WR, A_UNLK1, 8'h80, G_CMD, C_ALW);
        4'd3: s = mk(K_WR, A_UNLK1, 8'hAA, G_CMD, C_ALW);
        4'd4: s = mk(K_WR, A_UNLK2, 8'h55, G_CMD, C_ALW);
        4'd5: begin
          if (op == OP_SECT)      s = mk(K_WR, A_TGT, 8'h30, G_CMD, C_ALW);
          else if (op == OP_BLK)  s = mk(K_WR, A_TGT, 8'h50, G_CMD, C_ALW);
          else                    s = mk(K_WR, A_UNLK1, 8'h10, G_CMD, C_ALW);
        end
        4'd6: s = mk(K_POLL, A_UNLK1, 8'h00, G_NONE, C_ALW);
        default: s = mk(K_END, A_UNLK1, 8'h00, G_NONE, C_ALW);
      endcase
    end
    return s;
  endfunction

  function automatic logic [15:0] mask_of(logic [1:0] sel);
    case (sel)
      2'd0:    return 16'hFFFF;
      2'd1:    return 16'h07FF;
      2'd2:    return 16'h0FFF;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic odd_parity(logic [7:0] v);
    return ^v;
  endfunction

endpackage

// File: rtl/flash_mask_dec.sv
module flash_mask_dec
  import flash_seq_pkg::*;
(
  input  logic [1:0]  sel,
  output logic [15:0] mask,
  output logic        valid
);
  assign mask  = mask_of(sel);
  assign valid = (sel != 2'd3);
endmodule

// File: rtl/flash_gap_timer.sv
module flash_gap_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/flash_id_capture.sv
module flash_id_capture
  import flash_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        cap,
  input  addr_src_e   src,
  input  logic [7:0]  rdata,
  output logic [15:0] mfr_id,
  output logic [15:0] dev_id,
  output logic        mfr_cont,
  output logic        dev_cont
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mfr_id <= '0;
      dev_id <= '0;
    end else if (clear) begin
      mfr_id <= '0;
      dev_id <= '0;
    end else if (cap) begin
      case (src)
        A_ID_M0: mfr_id <= {8'h00, rdata};
        A_ID_D0: dev_id <= {8'h00, rdata};
        A_ID_M1: mfr_id <= {mfr_id[7:0], rdata};
        A_ID_D1: dev_id <= {dev_id[7:0], rdata};
        default: ;
      endcase
    end
  end

  assign mfr_cont = (mfr_id == {8'h00, CONT_CODE});
  assign dev_cont = (dev_id == {8'h00, CONT_CODE});
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W         = 16,
  parameter int unsigned CLK_MHZ        = 50,
  parameter int unsigned CMD_GAP_US     = 10,
  parameter int unsigned PROBE_ENTRY_US = 10000,
  parameter int unsigned PROBE_EXIT_US  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [1:0]        mask_sel,
  input  logic              long_exit,
  input  logic [ADDR_W-1:0] target_addr,
  input  logic [15:0]       exp_mfr,
  input  logic [15:0]       exp_dev,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  output logic              poll_req,
  input  logic              poll_done,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [15:0]       mfr_id,
  output logic [15:0]       dev_id,
  output logic              id_match,
  output logic              parity_warn
);
  localparam int unsigned CMD_CYC   = CLK_MHZ * CMD_GAP_US;
  localparam int unsigned ENTRY_CYC = CLK_MHZ * PROBE_ENTRY_US;
  localparam int unsigned EXIT_CYC  = CLK_MHZ * PROBE_EXIT_US;
  localparam int unsigned PUNLK_CYC = (PROBE_ENTRY_US != 0) ? CMD_CYC : 0;
  localparam int unsigned XUNLK_CYC = (PROBE_EXIT_US != 0) ? CMD_CYC : 0;
  localparam int unsigned MAX_A     = (CMD_CYC > ENTRY_CYC) ? CMD_CYC : ENTRY_CYC;
  localparam int unsigned MAX_CYC   = (MAX_A > EXIT_CYC) ? MAX_A : EXIT_CYC;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 2);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP, S_POLL} state_e;

  state_e            state;
  logic [3:0]        pc;
  logic [2:0]        op_q;
  logic              long_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [15:0]       mask_q;
  logic              cap_pend;
  addr_src_e         cap_src;

  logic [15:0] sel_mask;
  logic        sel_valid;
  logic        gap_expired;
  logic        mfr_cont, dev_cont;

  // Named internal events
  step_t cur;
  logic  skip;
  logic  accept;
  logic  reject;
  logic  issue_wr;
  logic  issue_rd;
  logic  enter_poll;
  logic  finish;

  function automatic logic [ADDR_W-1:0] addr_of(addr_src_e a, logic [15:0] m, logic [ADDR_W-1:0] t);
    case (a)
      A_UNLK1: return ADDR_W'(UNLK_A1 & m);
      A_UNLK2: return ADDR_W'(UNLK_A2 & m);
      A_TGT:   return t;
      A_ID_M0: return ADDR_W'(16'h0000);
      A_ID_D0: return ADDR_W'(16'h0001);
      A_ID_M1: return ADDR_W'(16'h0100);
      A_ID_D1: return ADDR_W'(16'h0101);
      default: return '0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] gap_of(gap_src_e g);
    case (g)
      G_CMD:   return CNT_W'(CMD_CYC);
      G_PUNLK: return CNT_W'(PUNLK_CYC);
      G_ENTRY: return CNT_W'(ENTRY_CYC);
      G_XUNLK: return CNT_W'(XUNLK_CYC);
      G_EXIT:  return CNT_W'(EXIT_CYC);
      default: return '0;
    endcase
  endfunction

  flash_mask_dec u_mask (
    .sel   (mask_sel),
    .mask  (sel_mask),
    .valid (sel_valid)
  );

  assign cur = step_of(op_q, pc);

  always_comb begin
    case (cur.cond)
      C_MCONT: skip = !mfr_cont;
      C_DCONT: skip = !dev_cont;
      C_LONG:  skip = !long_q;
      default: skip = 1'b0;
    endcase
  end

  assign accept     = (state == S_IDLE) && start && sel_valid && (op <= OP_PSET);
  assign reject     = (state == S_IDLE) && start && !(sel_valid && (op <= OP_PSET));
  assign issue_wr   = (state == S_RUN) && !skip && (cur.kind == K_WR);
  assign issue_rd   = (state == S_RUN) && !skip && (cur.kind == K_RD);
  assign enter_poll = (state == S_RUN) && (cur.kind == K_POLL);
  assign finish     = (state == S_RUN) && (cur.kind == K_END);

  flash_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue_wr || issue_rd),
    .load_val (gap_of(cur.gsrc)),
    .dec      (state == S_GAP),
    .expired  (gap_expired)
  );

  flash_id_capture u_ids (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .cap      (cap_pend),
    .src      (cap_src),
    .rdata    (bus_rdata),
    .mfr_id   (mfr_id),
    .dev_id   (dev_id),
    .mfr_cont (mfr_cont),
    .dev_cont (dev_cont)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      pc          <= '0;
      op_q        <= OP_PROBE;
      long_q      <= 1'b0;
      tgt_q       <= '0;
      mask_q      <= 16'hFFFF;
      bus_wr      <= 1'b0;
      bus_rd      <= 1'b0;
      bus_addr    <= '0;
      bus_wdata   <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
      id_match    <= 1'b0;
      parity_warn <= 1'b0;
      cap_pend    <= 1'b0;
      cap_src     <= A_ID_M0;
    end else begin
      bus_wr   <= 1'b0;
      bus_rd   <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      cap_pend <= issue_rd;
      if (issue_rd) cap_src <= cur.asrc;
      case (state)
        S_IDLE: begin
          if (accept) begin
            state       <= S_RUN;
            pc          <= '0;
            op_q        <= op;
            long_q      <= long_exit;
            tgt_q       <= target_addr;
            mask_q      <= sel_mask;
            id_match    <= 1'b0;
            parity_warn <= 1'b0;
          end else if (reject) begin
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
        S_RUN: begin
          if (skip) begin
            pc <= pc + 4'd1;
          end else if (issue_wr || issue_rd) begin
            bus_wr    <= issue_wr;
            bus_rd    <= issue_rd;
            bus_addr  <= addr_of(cur.asrc, mask_q, tgt_q);
            bus_wdata <= issue_wr ? cur.data : 8'h00;
            pc        <= pc + 4'd1;
            state     <= S_GAP;
          end else if (enter_poll) begin
            pc    <= pc + 4'd1;
            state <= S_POLL;
          end else if (finish) begin
            state <= S_IDLE;
            done  <= 1'b1;
            if (op_q == OP_PROBE) begin
              id_match    <= (mfr_id == exp_mfr) && (dev_id == exp_dev);
              parity_warn <= !odd_parity(mfr_id[7:0]);
            end
          end
        end
        S_GAP: begin
          if (gap_expired) state <= S_RUN;
        end
        S_POLL: begin
          if (poll_done) state <= S_RUN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign poll_req = (state == S_POLL);

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              poll_req,
  input logic              poll_done,
  input logic [15:0]       act_mask
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(bus_wr || bus_rd)); // R2

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |=> !(bus_wr || bus_rd)); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd)); // R5

  AST_UNLK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata == 8'hAA) |-> (bus_addr == ADDR_W'(16'h5555 & act_mask))); // R1

  AST_UNLK_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata == 8'h55) |-> (bus_addr == ADDR_W'(16'h2AAA & act_mask))); // R1

  AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |-> (busy && !bus_wr && !bus_rd)); // R11

  AST_POLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_req && !poll_done) |=> poll_req); // R11

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !busy)); // R2

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ($past(busy) && !busy)); // R12
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .poll_req  (poll_req),
  .poll_done (poll_done),
  .act_mask  (mask_q)
);

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ        = 1;
  localparam int CMD_US     = 10;
  localparam int ENTRY_US   = 100;
  localparam int EXIT_US    = 40;
  localparam int CMD_G      = MHZ * CMD_US;
  localparam int ENTRY_G    = MHZ * ENTRY_US;
  localparam int EXIT_G     = MHZ * EXIT_US;
  localparam int PUNLK_G    = (ENTRY_US != 0) ? CMD_G : 0;
  localparam int XUNLK_G    = (EXIT_US != 0) ? CMD_G : 0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [1:0]  sel_i = 2'd0;
  logic        long_i = 1'b0;
  logic [15:0] tgt_i = 16'h0;
  logic [15:0] emfr_i = 16'h0;
  logic [15:0] edev_i = 16'h0;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        poll_req;
  logic        poll_done = 1'b0;
  logic        busy, done, err, id_match, parity_warn;
  logic [15:0] mfr_id, dev_id;

  logic [7:0] mem_m0 = 8'h00, mem_d0 = 8'h00, mem_m1 = 8'h00, mem_d1 = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    case (bus_addr)
      16'h0000: bus_rdata = mem_m0;
      16'h0001: bus_rdata = mem_d0;
      16'h0100: bus_rdata = mem_m1;
      16'h0101: bus_rdata = mem_d1;
      default:  bus_rdata = 8'hFF;
    endcase
  end

  flash_cmd_seq #(
    .ADDR_W(16), .CLK_MHZ(MHZ), .CMD_GAP_US(CMD_US),
    .PROBE_ENTRY_US(ENTRY_US), .PROBE_EXIT_US(EXIT_US)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start_i), .op(op_i), .mask_sel(sel_i),
    .long_exit(long_i), .target_addr(tgt_i), .exp_mfr(emfr_i), .exp_dev(edev_i),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .poll_req(poll_req), .poll_done(poll_done),
    .busy(busy), .done(done), .err(err), .mfr_id(mfr_id), .dev_id(dev_id),
    .id_match(id_match), .parity_warn(parity_warn)
  );

  typedef struct {
    bit          wr;
    logic [15:0] addr;
    logic [7:0]  data;
    int          gap;
  } exp_t;

  exp_t expq[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;
  int   last_cyc = -1000;
  int   done_cnt = 0;
  int   tail_gap = 0;
  int   prev_gap = 0;
  bit   exp_err_now = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Driver helpers: queue the bus cycles the requirements call for
  task automatic push_wr(input logic [15:0] a, input logic [7:0] d, input int g_after);
    exp_t e;
    e.wr = 1; e.addr = a; e.data = d; e.gap = prev_gap;
    expq.push_back(e);
    prev_gap = g_after;
  endtask

  task automatic push_rd(input logic [15:0] a, input int g_after);
    exp_t e;
    e.wr = 0; e.addr = a; e.data = 8'h00; e.gap = prev_gap;
    expq.push_back(e);
    prev_gap = g_after;
  endtask

  task automatic push_unlock(input logic [15:0] m, input int g);
    push_wr(16'h5555 & m, 8'hAA, g);
    push_wr(16'h2AAA & m, 8'h55, g);
  endtask

  function automatic logic [15:0] bench_mask(input logic [1:0] s);
    if (s == 2'd1) return 16'h07FF;
    if (s == 2'd2) return 16'h0FFF;
    return 16'hFFFF;
  endfunction

  task automatic run_op(input logic [2:0] o, input logic [1:0] s, input bit lng,
                        input logic [15:0] t, input bit inject, input bit exp_err);
    int base;
    bit inj;
    base = done_cnt;
    inj = 0;
    exp_err_now = exp_err;
    op_i = o; sel_i = s; long_i = lng; tgt_i = t;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (!exp_err) chk(busy == 1'b1, "R12", "busy after start", busy, 1);
    else          chk(busy == 1'b0, "R2", "busy on rejected start", busy, 0);
    while (!done) begin
      if (inject && poll_req && !inj) begin
        start_i = 1'b1; op_i = 3'd4; inj = 1;
      end else begin
        start_i = 1'b0; op_i = o;
      end
      @(negedge clk);
    end
    start_i = 1'b0; op_i = o;
    chk(err == exp_err, "R2", "err at done", err, exp_err);
    chk(busy == 1'b0, "R12", "busy at done", busy, 0);
    repeat (4) @(negedge clk);
    chk(done_cnt - base == 1, "R12", "done pulses per operation", done_cnt - base, 1);
    if (inject) chk(inj, "R11", "poll wait observed", inj, 1);
  endtask

  task automatic do_pset(input logic [1:0] s);
    logic [15:0] m;
    m = bench_mask(s);
    prev_gap = 0;
    push_unlock(m, CMD_G);                  // R1
    push_wr(16'h5555 & m, 8'hA0, CMD_G);    // R3
    tail_gap = CMD_G;
    cur_req = "R3";
    run_op(3'd4, s, 0, 16'h0, 0, 0);
  endtask

  task automatic do_erase(input logic [2:0] o, input logic [1:0] s,
                          input logic [15:0] t, input bit inject);
    logic [15:0] m;
    m = bench_mask(s);
    prev_gap = 0;
    push_unlock(m, CMD_G);
    push_wr(16'h5555 & m, 8'h80, CMD_G);
    push_unlock(m, CMD_G);
    if (o == 3'd1)      push_wr(t, 8'h30, CMD_G);          // R4 sector
    else if (o == 3'd2) push_wr(t, 8'h50, CMD_G);          // R4 block
    else                push_wr(16'h5555 & m, 8'h10, CMD_G); // R4 device
    tail_gap = CMD_G;
    cur_req = "R4";
    run_op(o, s, 0, t, inject, 0);
  endtask

  task automatic do_probe(input logic [1:0] s, input bit lng);
    logic [15:0] m;
    m = bench_mask(s);
    prev_gap = 0;
    push_unlock(m, PUNLK_G);
    push_wr(16'h5555 & m, 8'h90, ENTRY_G);  // R5
    push_rd(16'h0000, 0);
    push_rd(16'h0001, 0);
    if (mem_m0 == 8'h7F) push_rd(16'h0100, 0); // R6
    if (mem_d0 == 8'h7F) push_rd(16'h0101, 0); // R6
    if (lng) push_unlock(m, XUNLK_G);          // R7
    push_wr(16'h5555 & m, 8'hF0, EXIT_G);      // R7
    tail_gap = EXIT_G;
    cur_req = "R5";
    run_op(3'd0, s, lng, 16'h0, 0, 0);
  endtask

  // Monitor: pops expected bus cycles and measures gaps
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n && (bus_wr || bus_rd)) begin
        if (expq.size() == 0) begin
          chk(0, cur_req, "unexpected bus cycle at address", bus_addr, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(bus_wr == e.wr, cur_req, "cycle kind (1=write)", bus_wr, e.wr);
          chk(bus_addr == e.addr, "R1", "cycle address", bus_addr, e.addr);
          if (e.wr) chk(bus_wdata == e.data, cur_req, "write data", bus_wdata, e.data);
          chk(cyc - last_cyc - 1 >= e.gap, "R8", "idle clocks before cycle", cyc - last_cyc - 1, e.gap);
        end
        last_cyc = cyc;
      end
      if (rst_n && done) begin
        done_cnt++;
        chk(expq.size() == 0, cur_req, "cycles missing at done", expq.size(), 0);
        if (!exp_err_now)
          chk(cyc - last_cyc - 1 >= tail_gap, "R8", "idle clocks before done", cyc - last_cyc - 1, tail_gap);
        expq.delete();
      end
    end
  end

  // External ready poller model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && poll_req) begin
        repeat (6) @(negedge clk);
        chk(poll_req == 1'b1, "R11", "poll_req held until acknowledge", poll_req, 1);
        poll_done = 1'b1;
        @(negedge clk);
        poll_done = 1'b0;
        chk(poll_req == 1'b0, "R11", "poll_req drops after acknowledge", poll_req, 0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R12", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R12", "reset busy", busy, 0);
    chk(done == 1'b0, "R12", "reset done", done, 0);
    chk(!bus_wr && !bus_rd, "R8", "reset bus idle", {bus_wr, bus_rd}, 0);
    chk(poll_req == 1'b0, "R11", "reset poll_req", poll_req, 0);

    // R3 program setup, full mask
    do_pset(2'd0);
    // R3 with narrow mask (R2 mask 0x07FF)
    do_pset(2'd1);

    // R4 sector erase, mask 0x07FF, restart attempt during poll (R12)
    do_erase(3'd1, 2'd1, 16'h1234, 1);
    // R4 block erase, mask 0x0FFF
    do_erase(3'd2, 2'd2, 16'hBEEF, 0);
    // R4 device erase, full mask
    do_erase(3'd3, 2'd0, 16'h4321, 0);

    // R5 probe, plain IDs, short exit; odd-parity maker (R10)
    mem_m0 = 8'hBF; mem_d0 = 8'hB6; emfr_i = 16'h00BF; edev_i = 16'h00B6;
    do_probe(2'd0, 0);
    chk(mfr_id == 16'h00BF, "R5", "maker id", mfr_id, 16'h00BF);
    chk(dev_id == 16'h00B6, "R5", "device id", dev_id, 16'h00B6);
    chk(id_match == 1'b1, "R9", "match on equal ids", id_match, 1);
    chk(parity_warn == 1'b0, "R10", "no warning for odd parity", parity_warn, 0);

    // R6 both continuation codes, R7 long exit, mask 0x0FFF
    mem_m0 = 8'h7F; mem_m1 = 8'h9D; mem_d0 = 8'h7F; mem_d1 = 8'h21;
    emfr_i = 16'h7F9D; edev_i = 16'h7F21;
    do_probe(2'd2, 1);
    chk(mfr_id == 16'h7F9D, "R6", "extended maker id", mfr_id, 16'h7F9D);
    chk(dev_id == 16'h7F21, "R6", "extended device id", dev_id, 16'h7F21);
    chk(id_match == 1'b1, "R9", "match on extended ids", id_match, 1);

    // R6 device-only continuation, R10 even parity, R9 mismatch
    mem_m0 = 8'h03; mem_d0 = 8'h7F; mem_d1 = 8'h44;
    emfr_i = 16'h0003; edev_i = 16'h0044;
    do_probe(2'd1, 0);
    chk(mfr_id == 16'h0003, "R6", "plain maker id", mfr_id, 16'h0003);
    chk(dev_id == 16'h7F44, "R6", "device extended only", dev_id, 16'h7F44);
    chk(id_match == 1'b0, "R9", "mismatch on device id", id_match, 0);
    chk(parity_warn == 1'b1, "R10", "warning for even parity", parity_warn, 1);

    // R2 invalid mask select and invalid op code
    cur_req = "R2";
    tail_gap = 0;
    run_op(3'd1, 2'd3, 0, 16'h0, 0, 1);
    run_op(3'd6, 2'd0, 0, 16'h0, 0, 1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule